// File: doc/BRIEF.md
# Pulse-Width Fault Code Blinker

This block shows a 32-bit fault value on one LED as a repeating serial pulse code, so that a board with no other output can still report why it stopped. A single-cycle trigger latches the code and starts the display. Each bit is sent as an off interval followed by an on interval. The on interval is short for a 0 and three times as long for a 1. The bits go out most significant first. After bit 0 the LED stays dark for a long gap so that frames can be told apart. The display then restarts at the top bit and repeats until reset.

All intervals are whole multiples of one base period. A two-stage prescaler builds the base period. The first stage divides the clock down to a short step, nominally 100 us. The second stage counts steps into a base period, nominally 1000 steps, or 100 ms. Both divisors are parameters, so simulation can use very small values. The LED's active level is also a parameter.

Top module: `fault_blinker`

## Requirements
- R1: While reset is high, and after reset until a trigger is accepted, the LED is at its off level and `busy_o` is 0.
- R2: A trigger sampled while idle latches `code_i` and starts the display. From the next cycle, `busy_o` is 1.
- R3: Bits are shown from bit 31 down to bit 0. Each bit starts with the LED off for exactly one base period, beginning in the cycle after the trigger edge.
- R4: After its off period, the LED is on for one base period if the bit is 0 and for three base periods if the bit is 1. The LED then turns off.
- R5: After bit 0, the LED stays off for ten base periods. The frame then restarts at bit 31, and this repeats for as long as reset stays low.
- R6: Changes on `code_i` after the trigger has been accepted have no effect on the LED.
- R7: A trigger that arrives while `busy_o` is 1 is ignored. This includes a trigger in the last cycle of the gap.
- R8: One base period equals TICK_DIV × STEPS_PER_UNIT clock cycles. The default is 1000 steps per base period.
- R9: With LED_ACTIVE_HIGH = 1, on is 1 and off is 0. With LED_ACTIVE_HIGH = 0, both levels are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start pulse. Accepted only while idle. |
| code_i | input | 32 | Fault value, latched when the trigger is accepted |
| led_o | output | 1 | LED drive, at the level set by LED_ACTIVE_HIGH |
| busy_o | output | 1 | High from the accepted trigger until reset |

## Verification
The two functions that can fall in the same cycle are the frame wrap at the end of the gap and the arrival of a new trigger. The bench drives a trigger with a different code exactly in the last gap cycle. It then requires the next frame to replay the originally latched code, cycle for cycle. In the same way, the bench changes `code_i` alone in the middle of a frame and judges the result against the waveform it computes on its own from the latched value.

// File: rtl/blink_pkg.sv
package blink_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SPACE = 2'd1,
        PH_MARK  = 2'd2,
        PH_GAP   = 2'd3
    } phase_e;

    // Length, in base periods, of the interval the sequencer is in.
    function automatic int unsigned phase_units(
        input phase_e      ph,
        input logic        bit_val,
        input int unsigned space_u,
        input int unsigned zero_u,
        input int unsigned one_u,
        input int unsigned gap_u
    );
        case (ph)
            PH_SPACE: return space_u;
            PH_MARK:  return bit_val ? one_u : zero_u;
            PH_GAP:   return gap_u;
            default:  return 1;
        endcase
    endfunction

    function automatic int unsigned max4(
        input int unsigned a,
        input int unsigned b,
        input int unsigned c,
        input int unsigned d
    );
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/blink_modcnt.sv
module blink_modcnt #(
    parameter int unsigned MOD = 4
) (
    input  logic clk,
    input  logic clr_i,
    input  logic en_i,
    output logic wrap_o
);
    localparam int unsigned CW = (MOD > 1) ? $clog2(MOD) : 1;

    logic [CW-1:0] cnt;

    assign wrap_o = en_i && (cnt == CW'(MOD - 1));

    always_ff @(posedge clk) begin
        if (clr_i)       cnt <= '0;
        else if (en_i)   cnt <= wrap_o ? '0 : cnt + 1'b1;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (clr_i)
        32'(cnt) < MOD); // R8
endmodule

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int unsigned TICK_DIV       = 10000,
    parameter int unsigned STEPS_PER_UNIT = 1000
) (
    input  logic clk,
    input  logic clr_i,
    output logic unit_tick_o
);
    logic step_wrap;
    logic unit_wrap;

    blink_modcnt #(.MOD(TICK_DIV)) u_step (
        .clk    (clk),
        .clr_i  (clr_i),
        .en_i   (1'b1),
        .wrap_o (step_wrap)
    );

    blink_modcnt #(.MOD(STEPS_PER_UNIT)) u_unit (
        .clk    (clk),
        .clr_i  (clr_i),
        .en_i   (step_wrap),
        .wrap_o (unit_wrap)
    );

    assign unit_tick_o = unit_wrap;

    AST_UNIT_NEEDS_STEP: assert property (@(posedge clk) disable iff (clr_i)
        unit_tick_o |-> step_wrap); // R8
endmodule

// File: rtl/blink_sequencer.sv
module blink_sequencer
    import blink_pkg::*;
#(
    parameter int unsigned CODE_W      = 32,
    parameter int unsigned SPACE_UNITS = 1,
    parameter int unsigned ZERO_UNITS  = 1,
    parameter int unsigned ONE_UNITS   = 3,
    parameter int unsigned GAP_UNITS   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              unit_tick_i,
    output logic              start_o,
    output phase_e            phase_o
);
    localparam int unsigned IW   = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int unsigned MAXU = max4(SPACE_UNITS, ZERO_UNITS, ONE_UNITS, GAP_UNITS);
    localparam int unsigned UW   = $clog2(MAXU + 1);

    phase_e            phase;
    logic [IW-1:0]     bit_idx;
    logic [UW-1:0]     ucnt;
    logic [CODE_W-1:0] code_q;
    logic              cur_bit;
    logic              last_unit;
    int unsigned       cur_len;

    assign cur_bit   = code_q[bit_idx];
    assign cur_len   = phase_units(phase, cur_bit, SPACE_UNITS, ZERO_UNITS, ONE_UNITS, GAP_UNITS);
    assign last_unit = (ucnt == UW'(cur_len - 1));
    assign start_o   = (phase == PH_IDLE) && trig_i;
    assign phase_o   = phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
            ucnt    <= '0;
            code_q  <= '0;
        end else if (phase == PH_IDLE) begin
            if (trig_i) begin
                code_q  <= code_i;
                bit_idx <= IW'(CODE_W - 1);
                ucnt    <= '0;
                phase   <= PH_SPACE;
            end
        end else if (unit_tick_i) begin
            if (!last_unit) begin
                ucnt <= ucnt + 1'b1;
            end else begin
                ucnt <= '0;
                case (phase)
                    PH_SPACE: phase <= PH_MARK;
                    PH_MARK: begin
                        if (bit_idx == '0) begin
                            phase <= PH_GAP;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                            phase   <= PH_SPACE;
                        end
                    end
                    default: begin
                        bit_idx <= IW'(CODE_W - 1);
                        phase   <= PH_SPACE;
                    end
                endcase
            end
        end
    end

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) && ($past(phase) != PH_IDLE) |-> $stable(code_q)); // R6
    AST_MARK_AFTER_SPACE: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_MARK) |-> $past(phase) == PH_SPACE); // R3
    AST_GAP_AFTER_BIT0: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_GAP) |-> $past(bit_idx) == '0); // R5
    AST_NO_RETURN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> (phase != PH_IDLE)); // R7
endmodule

// File: rtl/fault_blinker.sv
module fault_blinker
    import blink_pkg::*;
#(
    parameter int unsigned TICK_DIV        = 10000,
    parameter int unsigned STEPS_PER_UNIT  = 1000,
    parameter bit          LED_ACTIVE_HIGH = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trig_i,
    input  logic [31:0] code_i,
    output logic        led_o,
    output logic        busy_o
);
    localparam logic LED_ON  = LED_ACTIVE_HIGH;
    localparam logic LED_OFF = ~LED_ACTIVE_HIGH;

    logic   unit_tick;
    logic   start;
    phase_e phase;

    blink_prescaler #(
        .TICK_DIV       (TICK_DIV),
        .STEPS_PER_UNIT (STEPS_PER_UNIT)
    ) u_pre (
        .clk         (clk),
        .clr_i       (rst | start),
        .unit_tick_o (unit_tick)
    );

    blink_sequencer #(
        .CODE_W      (32),
        .SPACE_UNITS (1),
        .ZERO_UNITS  (1),
        .ONE_UNITS   (3),
        .GAP_UNITS   (10)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig_i),
        .code_i      (code_i),
        .unit_tick_i (unit_tick),
        .start_o     (start),
        .phase_o     (phase)
    );

    assign busy_o = (phase != PH_IDLE);
    assign led_o  = (phase == PH_MARK) ? LED_ON : LED_OFF;

    AST_DARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> led_o == LED_OFF); // R1
    AST_BUSY_AFTER_TRIG: assert property (@(posedge clk) disable iff (rst)
        !busy_o && trig_i |=> busy_o && led_o == LED_OFF); // R2
endmodule

// File: tb/sim_fault_blinker.sv
module sim_fault_blinker;
    localparam int TD = 2;
    localparam int SP = 3;
    localparam int U  = TD * SP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_i = 1'b0;
    logic [31:0] code_i = '0;
    logic        led0, busy0, led1, busy1;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    fault_blinker #(.TICK_DIV(TD), .STEPS_PER_UNIT(SP), .LED_ACTIVE_HIGH(1'b1)) u0 (
        .clk(clk), .rst(rst), .trig_i(trig_i), .code_i(code_i),
        .led_o(led0), .busy_o(busy0));

    fault_blinker #(.TICK_DIV(TD), .STEPS_PER_UNIT(SP), .LED_ACTIVE_HIGH(1'b0)) u1 (
        .clk(clk), .rst(rst), .trig_i(trig_i), .code_i(code_i),
        .led_o(led1), .busy_o(busy1));

    function automatic int frame_units(input logic [31:0] c);
        return 64 + 2 * $countones(c) + 10;
    endfunction

    // Expected active-high LED level k cycles after the trigger edge.
    function automatic logic exp_led(input logic [31:0] c, input int k);
        int u;
        u = (k / U) % frame_units(c);
        for (int i = 31; i >= 0; i--) begin
            int m;
            if (u < 1) return 1'b0;
            u = u - 1;
            m = c[i] ? 3 : 1;
            if (u < m) return 1'b1;
            u = u - m;
        end
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trig_i = 1'b0;
        repeat (3) @(negedge clk);
        check(led0 == 1'b0, "R1", led0, 0);
        check(busy0 == 1'b0, "R1", busy0, 0);
        check(led1 == 1'b1, "R9", led1, 1);
        rst = 1'b0;
        repeat (2 * U) @(negedge clk);
        check(led0 == 1'b0 && busy0 == 1'b0, "R1", {led0, busy0}, 0);
    endtask

    // Trigger with code c, then run n cycles comparing against the model.
    // At cycle poke_at, drive poke_code and optionally a trigger.
    task automatic run(input logic [31:0] c, input int n, input int poke_at,
                       input logic [31:0] poke_code, input bit poke_trig, input string req);
        trig_i = 1'b1; code_i = c;
        @(posedge clk);
        @(negedge clk);
        trig_i = 1'b0;
        for (int k = 0; k < n; k++) begin
            check(busy0 == 1'b1, "R2", busy0, 1);
            check(led0 == exp_led(c, k), req, led0, exp_led(c, k));
            check(led1 == ~led0, "R9", led1, ~led0);
            trig_i = 1'b0;
            if (k == poke_at) begin
                code_i = poke_code;
                trig_i = poke_trig;
            end
            @(negedge clk);
        end
        trig_i = 1'b0;
    endtask

    task automatic t_msb_lsb();   // R3 R4 R5 R8
        do_reset();
        run(32'h8000_0001, 2 * frame_units(32'h8000_0001) * U + 5, -1, '0, 1'b0, "R3");
    endtask

    task automatic t_all_ones();  // R4 R5
        do_reset();
        run(32'hFFFF_FFFF, 2 * frame_units(32'hFFFF_FFFF) * U, -1, '0, 1'b0, "R4");
    endtask

    task automatic t_all_zero();  // R5 R8
        do_reset();
        run(32'h0000_0000, 3 * frame_units(32'h0) * U, -1, '0, 1'b0, "R5");
    endtask

    task automatic t_code_change(); // R6
        do_reset();
        run(32'hA5C3_0F71, 2 * frame_units(32'hA5C3_0F71) * U, 100, 32'h1234_5678, 1'b0, "R6");
    endtask

    task automatic t_retrig_wrap(); // R7: trigger in last gap cycle
        int f;
        f = frame_units(32'h6B00_00D2) * U;
        do_reset();
        run(32'h6B00_00D2, 2 * f, f - 1, 32'hFFFF_0000, 1'b1, "R7");
    endtask

    task automatic t_reset_mid(); // R1
        do_reset();
        run(32'h0F0F_0F0F, 40, -1, '0, 1'b0, "R3");
        rst = 1'b1;
        @(negedge clk);
        check(led0 == 1'b0 && busy0 == 1'b0, "R1", {led0, busy0}, 0);
        rst = 1'b0;
        repeat (20 * U) begin
            @(negedge clk);
            check(led0 == 1'b0 && busy0 == 1'b0, "R1", {led0, busy0}, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        t_msb_lsb();
        t_all_ones();
        t_all_zero();
        t_code_change();
        t_retrig_wrap();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule